// File: doc/BRIEF.md
# USB Host Controller Status and Interrupt-Enable Register Pair

This block holds the event status word and the interrupt-enable word of a USB host controller. Completion, error, port-change, frame-rollover and async-advance pulses from the controller core are captured into sticky status bits that software clears by writing ones. A parity error, master abort or target abort on the host system bus is captured into the host-error status bit and stops the controller at the same clock edge.

The upper half of the status word reports live state and cannot be written. That state is the halted flag, which is derived from the run/stop flop, and three schedule indications supplied by the schedule engine. An interrupt request is raised while any captured event bit is also enabled. The run/stop flop is set and cleared by strobes from the command register logic. Its value is exported so that the schedule machinery can follow it.

Top module: `usb_host_status_ctrl`

## Requirements
- R1: After reset the six event bits and the six enable bits are zero, run_stop is 0, irq is 0 and status bit 12 (halted) reads 1.
- R2: An event input high at a clock edge sets its status bit at that edge. The positions are: completion at bit 0, error completion at bit 1, port change at bit 2, frame list rollover at bit 3 and async advance at bit 5. The bit then stays set until it is cleared by software.
- R3: A write with reg_sel=0 clears every event bit (bits 0..5) whose reg_wdata bit is 1.
- R4: A parity error, master abort or target abort input high at an edge sets status bit 4 and clears run_stop at that same edge. This takes priority over a run-set strobe in the same cycle.
- R5: Status bit 12 reads 1 exactly when run_stop is 0, whatever the cause.
- R6: Status bit 13 reflects sched_reclaim, bit 14 reflects sched_periodic_on and bit 15 reflects sched_async_on, with no delay.
- R7: A write with reg_sel=1 loads reg_wdata[5:0] into the enable register. Reading with reg_sel=1 returns the enable bits at positions 0..5, and zero in all other bits.
- R8: irq is 1 exactly when some bit i in 0..5 has both the status bit and the enable bit set.
- R9: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R10: Writes to status bits 6..15 have no effect on the status word. A status write with a 0 in an event bit leaves that bit unchanged.
- R11: cmd_run_set sets run_stop at the next edge and cmd_run_clr clears it. When both strobes are high in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 interrupt enable |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| ev_complete | input | 1 | Normal transfer completion pulse |
| ev_error | input | 1 | Error completion pulse |
| ev_port_chg | input | 1 | Port change pulse |
| ev_frame_roll | input | 1 | Frame list rollover pulse |
| ev_async_adv | input | 1 | Async advance pulse |
| bus_parity_err | input | 1 | Host bus parity error |
| bus_master_abort | input | 1 | Host bus master abort |
| bus_target_abort | input | 1 | Host bus target abort |
| sched_async_on | input | 1 | Async schedule active |
| sched_periodic_on | input | 1 | Periodic schedule active |
| sched_reclaim | input | 1 | Reclamation flag |
| cmd_run_set | input | 1 | Run strobe from command logic |
| cmd_run_clr | input | 1 | Stop strobe from command logic |
| run_stop | output | 1 | Run/stop state |
| irq | output | 1 | Interrupt request |

## Verification
Event, error, write and run-strobe results are due at the first rising edge after the stimulus. The bench applies stimulus at a falling edge and samples half a period after the following rising edge. Reads, the schedule bits 13..15 and irq are combinational from registers and inputs, so the bench checks them in the same low clock phase after a short settle delay. An expected-state model is updated once per edge from the inputs applied at that edge. Every comparison therefore lands on the cycle where the registered value has changed.

// File: rtl/usbh_stat_pkg.sv
package usbh_stat_pkg;
  localparam int POS_COMPLETE = 0;
  localparam int POS_ERROR    = 1;
  localparam int POS_PORTCHG  = 2;
  localparam int POS_FROLL    = 3;
  localparam int POS_HOSTERR  = 4;
  localparam int POS_ASYNCADV = 5;
  localparam int POS_HALTED   = 12;
  localparam int POS_RECLAIM  = 13;
  localparam int POS_PERIODIC = 14;
  localparam int POS_ASYNC    = 15;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/usbh_rst_sync.sv
module usbh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/usbh_sticky_bit.sv
module usbh_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i;            // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/usbh_run_ctl.sv
module usbh_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_set_i,
  input  logic run_clr_i,
  input  logic fatal_i,
  output logic run_o
);
  logic run_q;
  logic run_d;
  logic run_en;

  always_comb begin
    run_en = run_set_i | run_clr_i | fatal_i;
    run_d  = run_set_i & ~run_clr_i & ~fatal_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_en) run_q <= run_d;
  end

  assign run_o = run_q;
endmodule

// File: rtl/usbh_irq_gen.sv
module usbh_irq_gen #(
  parameter int EVT_N = 6
) (
  input  logic [EVT_N-1:0] status_i,
  input  logic [EVT_N-1:0] enable_i,
  output logic             irq_o
);
  logic [EVT_N-1:0] hit;

  for (genvar i = 0; i < EVT_N; i++) begin : g_hit
    assign hit[i] = status_i[i] & enable_i[i];
  end

  assign irq_o = |hit;
endmodule

// File: rtl/usb_host_status_ctrl.sv
module usb_host_status_ctrl
  import usbh_stat_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EVT_N  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_complete,
  input  logic              ev_error,
  input  logic              ev_port_chg,
  input  logic              ev_frame_roll,
  input  logic              ev_async_adv,
  input  logic              bus_parity_err,
  input  logic              bus_master_abort,
  input  logic              bus_target_abort,
  input  logic              sched_async_on,
  input  logic              sched_periodic_on,
  input  logic              sched_reclaim,
  input  logic              cmd_run_set,
  input  logic              cmd_run_clr,
  output logic              run_stop,
  output logic              irq
);
  localparam int EVT_MSB = EVT_N - 1;

  logic             rst_sync_n;
  logic             host_err;
  logic [EVT_N-1:0] ev_vec;
  logic [EVT_N-1:0] clr_vec;
  logic [EVT_N-1:0] sticky_q;
  logic [EVT_N-1:0] inten_q;
  logic [EVT_N-1:0] inten_d;
  logic             inten_en;
  logic             stat_wr;

  usbh_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    host_err               = bus_parity_err | bus_master_abort | bus_target_abort;
    ev_vec                 = '0;
    ev_vec[POS_COMPLETE]   = ev_complete;
    ev_vec[POS_ERROR]      = ev_error;
    ev_vec[POS_PORTCHG]    = ev_port_chg;
    ev_vec[POS_FROLL]      = ev_frame_roll;
    ev_vec[POS_HOSTERR]    = host_err;
    ev_vec[POS_ASYNCADV]   = ev_async_adv;
    stat_wr                = reg_wr & (reg_sel_e'(reg_sel) == SEL_STATUS);
    inten_en               = reg_wr & (reg_sel_e'(reg_sel) == SEL_ENABLE);
    clr_vec                = stat_wr ? reg_wdata[EVT_MSB:0] : '0;
    inten_d                = reg_wdata[EVT_MSB:0];
  end

  for (genvar i = 0; i < EVT_N; i++) begin : g_sticky
    usbh_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_i (ev_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (sticky_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   inten_q <= '0;
    else if (inten_en) inten_q <= inten_d;
  end

  usbh_run_ctl u_run (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_set_i (cmd_run_set),
    .run_clr_i (cmd_run_clr),
    .fatal_i   (host_err),
    .run_o     (run_stop)
  );

  usbh_irq_gen #(.EVT_N(EVT_N)) u_irq (
    .status_i (sticky_q),
    .enable_i (inten_q),
    .irq_o    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel_e'(reg_sel) == SEL_STATUS) begin
      reg_rdata[EVT_MSB:0]   = sticky_q;
      reg_rdata[POS_HALTED]  = ~run_stop;
      reg_rdata[POS_RECLAIM] = sched_reclaim;
      reg_rdata[POS_PERIODIC]= sched_periodic_on;
      reg_rdata[POS_ASYNC]   = sched_async_on;
    end else begin
      reg_rdata[EVT_MSB:0]   = inten_q;
    end
  end
endmodule

// File: rtl/usbh_stat_chk.sv
module usbh_stat_chk #(
  parameter int EVT_N = 6
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [EVT_N-1:0] wmask,
  input logic [EVT_N-1:0] ev_vec,
  input logic [EVT_N-1:0] sticky_q,
  input logic [EVT_N-1:0] inten_q,
  input logic             host_err,
  input logic             cmd_run_set,
  input logic             cmd_run_clr,
  input logic             run_stop,
  input logic             irq
);
  // R2 and R9: any event seen at an edge is set after it, regardless of clears
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_vec != '0) |=> ((sticky_q & $past(ev_vec)) == $past(ev_vec)));

  // R3: write-one-to-clear with no competing event empties the written bits
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && !reg_sel && ev_vec == '0) |=> ((sticky_q & $past(wmask)) == '0));

  // R10: zero bits in a status write and idle cycles do not disturb sticky bits
  a_r10_zero_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_vec == '0) |=> ((sticky_q & ~($past(reg_wr && !reg_sel) ? $past(wmask) : '0))
                        == ($past(sticky_q) & ~($past(reg_wr && !reg_sel) ? $past(wmask) : '0))));

  // R4: host error stops the controller at the same edge, even against a run strobe
  a_r4_hosterr_stops: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_err |=> (!run_stop && sticky_q[4]));

  // R11: run strobe alone starts the controller
  a_r11_run_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_run_set && !cmd_run_clr && !host_err) |=> run_stop);

  // R8: a rising interrupt needs an enabled pending bit
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> ((sticky_q & inten_q) != '0));
endmodule

bind usb_host_status_ctrl usbh_stat_chk #(.EVT_N(EVT_N)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .wmask       (reg_wdata[EVT_N-1:0]),
  .ev_vec      (ev_vec),
  .sticky_q    (sticky_q),
  .inten_q     (inten_q),
  .host_err    (host_err),
  .cmd_run_set (cmd_run_set),
  .cmd_run_clr (cmd_run_clr),
  .run_stop    (run_stop),
  .irq         (irq)
);

// File: tb/sim_usb_host_status_ctrl.sv
`timescale 1ns/1ps
module sim_usb_host_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ev_complete = 1'b0, ev_error = 1'b0, ev_port_chg = 1'b0;
  logic        ev_frame_roll = 1'b0, ev_async_adv = 1'b0;
  logic        bus_parity_err = 1'b0, bus_master_abort = 1'b0, bus_target_abort = 1'b0;
  logic        sched_async_on = 1'b0, sched_periodic_on = 1'b0, sched_reclaim = 1'b0;
  logic        cmd_run_set = 1'b0, cmd_run_clr = 1'b0;
  logic        run_stop, irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] m_sticky;
  logic [5:0] m_en;
  logic       m_run;

  always #2 clk = ~clk;

  usb_host_status_ctrl u0 (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // one clock: drive at falling edge, model at rising edge, return at next falling edge
  task automatic cyc(input logic wr, input logic sel, input logic [15:0] wd,
                     input logic [5:0] ev, input int src, input logic rs, input logic rc);
    logic [5:0] clr;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    ev_complete = ev[0]; ev_error = ev[1]; ev_port_chg = ev[2];
    ev_frame_roll = ev[3]; ev_async_adv = ev[5];
    bus_parity_err = ev[4] && src == 0;
    bus_master_abort = ev[4] && src == 1;
    bus_target_abort = ev[4] && src == 2;
    cmd_run_set = rs; cmd_run_clr = rc;
    @(posedge clk);
    clr = (wr && !sel) ? wd[5:0] : 6'h0;
    m_sticky = ev | (m_sticky & ~clr);
    if (wr && sel) m_en = wd[5:0];
    if (ev[4]) m_run = 1'b0;
    else if (rc) m_run = 1'b0;
    else if (rs) m_run = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    {ev_complete, ev_error, ev_port_chg, ev_frame_roll, ev_async_adv} = '0;
    {bus_parity_err, bus_master_abort, bus_target_abort} = '0;
    cmd_run_set = 1'b0; cmd_run_clr = 1'b0;
  endtask

  function automatic logic [15:0] exp_status();
    logic [15:0] v = '0;
    v[5:0] = m_sticky;
    v[12]  = ~m_run;
    v[13]  = sched_reclaim;
    v[14]  = sched_periodic_on;
    v[15]  = sched_async_on;
    return v;
  endfunction

  task automatic check_all(input string req);
    reg_sel = 1'b0; #0.5;
    chk({req, " status"}, reg_rdata, exp_status());
    reg_sel = 1'b1; #0.5;
    chk({req, " enable"}, reg_rdata, {10'h0, m_en});
    chk({req, " irq"}, {15'h0, irq}, {15'h0, |(m_sticky & m_en)});
    chk({req, " run"}, {15'h0, run_stop}, {15'h0, m_run});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    m_sticky = '0; m_en = '0; m_run = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R5 halted
    check_all("R1");
    chk("R5 halted after reset", {15'h0, reg_rdata[12] | reg_sel}, 16'h1);

    // R11 run strobes
    cyc(0, 0, 0, 6'h0, 0, 1, 0); check_all("R11 set");
    cyc(0, 0, 0, 6'h0, 0, 1, 1); check_all("R11 both clear wins");
    cyc(0, 0, 0, 6'h0, 0, 1, 0); check_all("R11 set again");
    cyc(0, 0, 0, 6'h0, 0, 0, 1); check_all("R11 clear R5");

    // R2 single events at every non-error position, R3 clear afterwards
    for (int b = 0; b < 6; b++) begin
      if (b == 4) continue;
      cyc(0, 0, 0, 6'(1 << b), 0, 0, 0); check_all("R2 event");
      cyc(0, 0, 0, 6'h0, 0, 0, 0);       check_all("R2 sticky hold");
      cyc(1, 0, 16'(1 << b), 6'h0, 0, 0, 0); check_all("R3 w1c");
    end

    // R4 each bus error source, also against a run strobe in the same cycle
    for (int s = 0; s < 3; s++) begin
      cyc(0, 0, 0, 6'h0, 0, 1, 0);       check_all("R4 prep run");
      cyc(0, 0, 0, 6'h10, s, 0, 0);      check_all("R4 hosterr stops R5");
      cyc(0, 0, 0, 6'h10, s, 1, 0);      check_all("R4 beats run set");
      cyc(1, 0, 16'h0010, 6'h0, 0, 0, 0); check_all("R4 w1c");
    end

    // R6 schedule inputs
    for (int k = 0; k < 8; k++) begin
      {sched_async_on, sched_periodic_on, sched_reclaim} = 3'(k);
      check_all("R6 schedule bits");
    end
    {sched_async_on, sched_periodic_on, sched_reclaim} = 3'b000;

    // R10 writes to upper/reserved bits and zero bits ignored
    cyc(0, 0, 0, 6'h2f, 0, 0, 0);           check_all("R10 prep");
    cyc(1, 0, 16'hffc0, 6'h0, 0, 0, 0);     check_all("R10 upper ignored");
    cyc(1, 0, 16'h0000, 6'h0, 0, 0, 0);     check_all("R10 zero write holds");
    cyc(1, 0, 16'h0005, 6'h0, 0, 0, 0);     check_all("R3 partial clear");

    // R9 set and clear collide
    cyc(1, 0, 16'h003f, 6'h3f, 1, 0, 0);    check_all("R9 set wins");
    cyc(1, 0, 16'h003f, 6'h00, 0, 0, 0);    check_all("R3 clear all");

    // R7 enable write with upper bits, read back masked
    cyc(1, 1, 16'hffea, 6'h0, 0, 0, 0);     check_all("R7 enable write");

    // R8 exhaustive sweep of status pattern against enable pattern
    for (int p = 0; p < 64; p++) begin
      cyc(1, 0, 16'h003f, 6'h0, 0, 0, 0);
      cyc(0, 0, 0, 6'(p), 2, 0, 0);
      for (int e = 0; e < 64; e++) begin
        cyc(1, 1, 16'(e), 6'h0, 0, 0, 0);
        check_all("R8 sweep");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule